// File: doc/BRIEF.md
# Shift and Rotate Flag Generator

This block derives the status flags that a shift or rotate operation leaves behind. The data shifter sits elsewhere: it hands this block the operand it started from, the value it produced and the requested count. The block also takes the operation kind, the operand size (8, 16, 32 or 64 bits), a per-flag select mask and the flags in force before the operation. It returns the new flag vector.

Each kind has its own carry and overflow rule. Shift counts are masked to the operand size and clamped where a rule needs it. Rotates through carry reduce their count modulo the operand width plus one, and keep the incoming carry when that reduced count is zero. The zero, sign and parity flags follow the produced value, and the adjust flag is cleared. Only flags named in the select mask may change. A masked count of zero changes nothing. The logic is purely combinational, so the new flags are valid in the same cycle as the inputs.

Top module: `shift_flag_gen`

## Requirements
- R1: The flag vector is 7 bits with CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4, OF at bit 5 and ECF at bit 6. Every bit whose `sel_i` bit is 0 equals the same bit of `flags_i`, and the output follows the inputs combinationally.
- R2: When the masked shift count is zero, `flags_o` equals `flags_i` whatever the kind and the select mask.
- R3: `size_i` codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit operands. The count is masked to its low 5 bits for codes 0 to 2 and to its low 6 bits for code 3. Data sits in the low bits of `src_i` and `res_i`.
- R4: Kind 0, shift left: CF is source bit (W minus count) when the count is at most W, else 0. OF is that CF XOR the result MSB.
- R5: Kind 1, logical shift right: CF is source bit (count minus 1) when the count is at most W, else 0. OF is the source MSB.
- R6: Kind 2, arithmetic shift right: the count is clamped to W, and CF is source bit (clamped count minus 1). OF is 0.
- R7: Kind 3, rotate left: CF is the result LSB. OF is the result MSB XOR the result LSB.
- R8: Kind 4, rotate right: CF is the result MSB. OF is the XOR of the two most significant result bits.
- R9: Kind 5, rotate left through carry: r is the count modulo W+1. CF is the incoming CF when r is 0, else source bit (W minus r). OF is the new CF XOR the result MSB.
- R10: Kind 6, rotate right through carry: r is the count modulo W+1. CF is the incoming CF when r is 0, else source bit (r minus 1). OF is the incoming CF XOR the source MSB.
- R11: ECF, when selected, takes the same value as the CF rule of the active kind.
- R12: For a nonzero count, ZF is 1 when the W-bit result is zero, SF is the result MSB, PF is 1 when the low 8 result bits hold an even number of ones, and AF is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Operand before the shift |
| res_i | input | 64 | Value produced by the external shifter |
| amt_i | input | 6 | Requested shift or rotate count |
| kind_i | input | 3 | Operation kind (codes in R4 to R10) |
| size_i | input | 2 | Operand size code |
| sel_i | input | 7 | Flags this operation may update |
| flags_i | input | 7 | Flags before the operation |
| flags_o | output | 7 | Flags after the operation |

## Verification
The embedded checks assume that `kind_i` carries one of the seven defined codes and that `res_i` is consistent enough for the rotate overflow rules to be meaningful. No check compares `res_i` against `src_i`, so any value is legal. The stimulus drives only codes 0 to 6. It applies each input set and settles it before sampling, which keeps every combinational check on stable values. Directed cases aim at the count boundaries: masked-away upper count bits, counts just past the width, and rotate-through-carry counts whose reduced value is zero. A sweep over all kinds and sizes then compares the outputs with a model written from the requirements.

// File: rtl/sflag_pkg.sv
// Shared widths, kind and size codes, and flag positions for the
// shift/rotate flag generator. Assumes operands of at most 64 bits.
package sflag_pkg;
    localparam int DATA_W = 64;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int IDX_W  = CNT_W + 1;
    localparam int FLAG_N = 7;

    localparam int FI_CF  = 0;
    localparam int FI_PF  = 1;
    localparam int FI_AF  = 2;
    localparam int FI_ZF  = 3;
    localparam int FI_SF  = 4;
    localparam int FI_OF  = 5;
    localparam int FI_ECF = 6;

    typedef enum logic [2:0] {
        SK_SHL = 3'd0,
        SK_SHR = 3'd1,
        SK_SAR = 3'd2,
        SK_ROL = 3'd3,
        SK_ROR = 3'd4,
        SK_RCL = 3'd5,
        SK_RCR = 3'd6
    } shift_kind_e;

    typedef enum logic [1:0] {
        OSZ_8  = 2'd0,
        OSZ_16 = 2'd1,
        OSZ_32 = 2'd2,
        OSZ_64 = 2'd3
    } opsize_e;

    // Operand width in bits for a size code
    function automatic logic [IDX_W-1:0] op_width(input logic [1:0] s);
        return IDX_W'(8) << s;
    endfunction

    // Bit of a data word at a computed index, 0 when out of range
    function automatic logic pick(input logic [DATA_W-1:0] v,
                                  input logic [IDX_W-1:0] i);
        return (i < IDX_W'(DATA_W)) ? v[i[CNT_W-1:0]] : 1'b0;
    endfunction
endpackage

// File: rtl/sflag_count.sv
// Count conditioning: masks the raw count to the operand size, and
// derives the width-clamped count and the rotate-through-carry count
// (modulo width+1). Assumes the four fixed operand sizes.
module sflag_count
    import sflag_pkg::*;
(
    input  logic [CNT_W-1:0] amt_i,
    input  logic [1:0]       size_i,
    output logic [IDX_W-1:0] width_o,
    output logic [IDX_W-1:0] cnt_o,
    output logic [IDX_W-1:0] sat_o,
    output logic [IDX_W-1:0] rot_o,
    output logic             active_o
);
    // Mask, clamp and reduce the requested count
    always_comb begin
        width_o = op_width(size_i);
        if (opsize_e'(size_i) == OSZ_64) begin
            cnt_o = IDX_W'(amt_i);
        end else begin
            cnt_o = IDX_W'(amt_i[CNT_W-2:0]);
        end
        active_o = (cnt_o != '0);
        sat_o    = (cnt_o > width_o) ? width_o : cnt_o;
        case (opsize_e'(size_i))
            OSZ_8:   rot_o = cnt_o % IDX_W'(9);
            OSZ_16:  rot_o = cnt_o % IDX_W'(17);
            default: rot_o = cnt_o;
        endcase
    end

    // R6: clamped count never exceeds the operand width
    always_comb begin
        a_r6_sat_bounded: assert (sat_o <= width_o)
            else $error("sat count above width");
    end
endmodule

// File: rtl/sflag_carry.sv
// Carry and overflow rule selection per shift/rotate kind. Assumes the
// count inputs come from sflag_count and that kind codes 0..6 are used;
// other codes yield CF=OF=0.
module sflag_carry
    import sflag_pkg::*;
(
    input  logic [2:0]        kind_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [IDX_W-1:0]  width_i,
    input  logic [IDX_W-1:0]  cnt_i,
    input  logic [IDX_W-1:0]  sat_i,
    input  logic [IDX_W-1:0]  rot_i,
    input  logic              cf_in_i,
    output logic              cf_o,
    output logic              of_o
);
    logic [IDX_W-1:0] top_idx;
    logic             src_msb;
    logic             res_msb;
    logic             res_lsb;
    logic             res_nmsb;

    // Most significant positions of source and result for this size
    always_comb begin
        top_idx  = width_i - IDX_W'(1);
        src_msb  = pick(src_i, top_idx);
        res_msb  = pick(res_i, top_idx);
        res_nmsb = pick(res_i, width_i - IDX_W'(2));
        res_lsb  = res_i[0];
    end

    // Per-kind carry and overflow rules
    always_comb begin
        cf_o = 1'b0;
        of_o = 1'b0;
        case (shift_kind_e'(kind_i))
            SK_SHL: begin
                cf_o = (cnt_i <= width_i) ? pick(src_i, width_i - cnt_i) : 1'b0;
                of_o = cf_o ^ res_msb;
            end
            SK_SHR: begin
                cf_o = (cnt_i <= width_i) ? pick(src_i, cnt_i - IDX_W'(1)) : 1'b0;
                of_o = src_msb;
            end
            SK_SAR: begin
                cf_o = pick(src_i, sat_i - IDX_W'(1));
                of_o = 1'b0;
            end
            SK_ROL: begin
                cf_o = res_lsb;
                of_o = res_msb ^ res_lsb;
            end
            SK_ROR: begin
                cf_o = res_msb;
                of_o = res_msb ^ res_nmsb;
            end
            SK_RCL: begin
                cf_o = (rot_i == '0) ? cf_in_i : pick(src_i, width_i - rot_i);
                of_o = cf_o ^ res_msb;
            end
            SK_RCR: begin
                cf_o = (rot_i == '0) ? cf_in_i : pick(src_i, rot_i - IDX_W'(1));
                of_o = cf_in_i ^ src_msb;
            end
            default: begin
                cf_o = 1'b0;
                of_o = 1'b0;
            end
        endcase
    end

    // R6: arithmetic right shift by the width or more replicates the sign into CF
    always_comb begin
        if (shift_kind_e'(kind_i) == SK_SAR && cnt_i >= width_i) begin
            a_r6_sar_sign_carry: assert (cf_o == src_msb)
                else $error("sar carry not sign");
        end
    end

    // R8: rotate right overflow relates the new carry to the next bit down
    always_comb begin
        if (shift_kind_e'(kind_i) == SK_ROR) begin
            a_r8_ror_of: assert (of_o == (cf_o ^ res_nmsb))
                else $error("ror overflow mismatch");
        end
    end

    // R10: a zero reduced rotate-through-carry count keeps the carry
    always_comb begin
        if ((shift_kind_e'(kind_i) == SK_RCR || shift_kind_e'(kind_i) == SK_RCL)
            && rot_i == '0) begin
            a_r10_rc_keep_carry: assert (cf_o == cf_in_i)
                else $error("rc carry not kept");
        end
    end
endmodule

// File: rtl/sflag_status.sv
// Zero, sign, parity and adjust flags from the shifted value. One lane
// per operand size is built by a generate loop; the size code picks one.
// Assumes DATA_W is at least 64.
module sflag_status
    import sflag_pkg::*;
(
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        size_i,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o,
    output logic              af_o
);
    localparam int LANES = 4;

    logic [LANES-1:0] lane_zero;
    logic [LANES-1:0] lane_msb;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        assign lane_zero[g] = ~|res_i[LW-1:0];
        assign lane_msb[g]  = res_i[LW-1];
    end

    // Select the lane for this operand size and form the status bits
    always_comb begin
        zf_o = lane_zero[size_i];
        sf_o = lane_msb[size_i];
        pf_o = ~^res_i[7:0];
        af_o = 1'b0;
    end

    // R12: a zero result cannot have its sign bit set
    always_comb begin
        a_r12_zero_not_signed: assert (!(zf_o && sf_o))
            else $error("zero and sign both set");
    end
endmodule

// File: rtl/shift_flag_gen.sv
// Top of the shift/rotate flag generator. Combines the count, carry and
// status units and merges their flags into the incoming vector under the
// select mask. Purely combinational; assumes the external shifter has
// already produced res_i from src_i.
module shift_flag_gen
    import sflag_pkg::*;
(
    input  logic [63:0] src_i,
    input  logic [63:0] res_i,
    input  logic [5:0]  amt_i,
    input  logic [2:0]  kind_i,
    input  logic [1:0]  size_i,
    input  logic [6:0]  sel_i,
    input  logic [6:0]  flags_i,
    output logic [6:0]  flags_o
);
    logic [IDX_W-1:0]  width;
    logic [IDX_W-1:0]  cnt;
    logic [IDX_W-1:0]  sat;
    logic [IDX_W-1:0]  rot;
    logic              active;
    logic              cf_rule;
    logic              of_rule;
    logic              zf;
    logic              sf;
    logic              pf;
    logic              af;
    logic [FLAG_N-1:0] upd;

    sflag_count u_count (
        .amt_i    (amt_i),
        .size_i   (size_i),
        .width_o  (width),
        .cnt_o    (cnt),
        .sat_o    (sat),
        .rot_o    (rot),
        .active_o (active)
    );

    sflag_carry u_carry (
        .kind_i   (kind_i),
        .src_i    (src_i),
        .res_i    (res_i),
        .width_i  (width),
        .cnt_i    (cnt),
        .sat_i    (sat),
        .rot_i    (rot),
        .cf_in_i  (flags_i[FI_CF]),
        .cf_o     (cf_rule),
        .of_o     (of_rule)
    );

    sflag_status u_status (
        .res_i    (res_i),
        .size_i   (size_i),
        .zf_o     (zf),
        .sf_o     (sf),
        .pf_o     (pf),
        .af_o     (af)
    );

    // Assemble the candidate flag vector
    always_comb begin
        upd         = '0;
        upd[FI_CF]  = cf_rule;
        upd[FI_ECF] = cf_rule;
        upd[FI_OF]  = of_rule;
        upd[FI_ZF]  = zf;
        upd[FI_SF]  = sf;
        upd[FI_PF]  = pf;
        upd[FI_AF]  = af;
    end

    // Merge selected bits over the incoming flags when the count is live
    always_comb begin
        if (active) begin
            flags_o = (flags_i & ~sel_i) | (upd & sel_i);
        end else begin
            flags_o = flags_i;
        end
    end

    // R1: unselected flags pass through
    always_comb begin
        a_r1_unselected_hold: assert ((flags_o & ~sel_i) == (flags_i & ~sel_i))
            else $error("unselected flag changed");
    end

    // R2: an inactive count leaves the flags alone
    always_comb begin
        if (!active) begin
            a_r2_zero_count_hold: assert (flags_o == flags_i)
                else $error("flags changed on zero count");
        end
    end

    // R11: selected ECF and CF agree after a live shift
    always_comb begin
        if (active && sel_i[FI_CF] && sel_i[FI_ECF]) begin
            a_r11_ecf_matches_cf: assert (flags_o[FI_ECF] == flags_o[FI_CF])
                else $error("ecf differs from cf");
        end
    end

    // R12: selected AF is cleared by a live shift
    always_comb begin
        if (active && sel_i[FI_AF]) begin
            a_r12_af_cleared: assert (flags_o[FI_AF] == 1'b0)
                else $error("af not cleared");
        end
    end
endmodule

// File: tb/sim_shift_flag_gen.sv
module sim_shift_flag_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic [63:0] src, res;
    logic [5:0]  amt;
    logic [2:0]  kind;
    logic [1:0]  size;
    logic [6:0]  sel, fin, fout;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_flag_gen u0 (
        .src_i   (src),
        .res_i   (res),
        .amt_i   (amt),
        .kind_i  (kind),
        .size_i  (size),
        .sel_i   (sel),
        .flags_i (fin),
        .flags_o (fout)
    );

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: flags actual=%02h expected=%02h (kind=%0d size=%0d amt=%0d)",
                     req, got, exp, kind, size, amt);
        end
    endtask

    task automatic apply(input logic [2:0] k, input logic [1:0] s, input logic [5:0] a,
                         input logic [63:0] sv, input logic [63:0] rv,
                         input logic [6:0] m, input logic [6:0] f);
        @(negedge clk);
        kind = k; size = s; amt = a; src = sv; res = rv; sel = m; fin = f;
        #1;
    endtask

    // Reference model written from the requirements
    function automatic logic [6:0] model(input logic [2:0] k, input logic [1:0] s,
                                         input logic [5:0] a, input logic [63:0] sv,
                                         input logic [63:0] rv, input logic [6:0] m,
                                         input logic [6:0] f);
        int w, n, e, r;
        logic [63:0] sm, rm;
        logic c, o, cin;
        logic [6:0] u;
        w = 8 << s;
        n = (s == 2'd3) ? int'(a) : int'(a & 6'h1f);
        if (n == 0) return f;
        sm = (w == 64) ? sv : (sv & ((64'd1 << w) - 64'd1));
        rm = (w == 64) ? rv : (rv & ((64'd1 << w) - 64'd1));
        cin = f[0];
        r = n % (w + 1);
        c = 1'b0; o = 1'b0;
        case (k)
            3'd0: begin c = (n <= w) ? sm[w-n] : 1'b0; o = c ^ rm[w-1]; end
            3'd1: begin c = (n <= w) ? sm[n-1] : 1'b0; o = sm[w-1]; end
            3'd2: begin e = (n > w) ? w : n; c = sm[e-1]; o = 1'b0; end
            3'd3: begin c = rm[0]; o = rm[w-1] ^ rm[0]; end
            3'd4: begin c = rm[w-1]; o = rm[w-1] ^ rm[w-2]; end
            3'd5: begin c = (r == 0) ? cin : sm[w-r]; o = c ^ rm[w-1]; end
            3'd6: begin c = (r == 0) ? cin : sm[r-1]; o = cin ^ sm[w-1]; end
            default: begin c = 1'b0; o = 1'b0; end
        endcase
        u = {c, o, rm[w-1], (rm == 64'd0), 1'b0, ~^rm[7:0], c};
        return (f & ~m) | (u & m);
    endfunction

    function automatic string kind_req(input int k);
        case (k)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic t_idle();
        apply(3'd0, 2'd0, 6'd0, 64'd0, 64'd0, 7'h00, 7'h00);
        chk("R2 idle", fout, 7'h00);
    endtask

    task automatic t_count_mask();
        apply(3'd1, 2'd0, 6'h20, 64'hFF, 64'h0, 7'h7F, 7'h55);
        chk("R3 upper count bit masked for 8-bit", fout, 7'h55);
        apply(3'd1, 2'd3, 6'h00, 64'hFF, 64'h0, 7'h7F, 7'h2A);
        chk("R2 zero count 64-bit", fout, 7'h2A);
        apply(3'd1, 2'd3, 6'h20, 64'h0000_0000_8000_0000, 64'h1, 7'h41, 7'h00);
        chk("R3 6-bit count for 64-bit", fout, 7'h41);
    endtask

    task automatic t_shl();
        apply(3'd0, 2'd0, 6'd1, 64'h80, 64'h00, 7'h7F, 7'h00);
        chk("R4 shl carry and overflow", fout, 7'h6B);
    endtask

    task automatic t_shr_clamp();
        apply(3'd1, 2'd1, 6'd17, 64'hFFFF, 64'h0, 7'h7F, 7'h00);
        chk("R5 shr count past width", fout, 7'h2A);
    endtask

    task automatic t_sar_clamp();
        apply(3'd2, 2'd0, 6'd20, 64'h80, 64'hFF, 7'h7F, 7'h00);
        chk("R6 sar clamped count", fout, 7'h53);
    endtask

    task automatic t_rotates();
        apply(3'd3, 2'd2, 6'd1, 64'h0, 64'h8000_0001, 7'h7F, 7'h00);
        chk("R7 rol", fout, 7'h51);
        apply(3'd4, 2'd2, 6'd3, 64'h0, 64'h4000_0000, 7'h7F, 7'h00);
        chk("R8 ror", fout, 7'h22);
    endtask

    task automatic t_rotate_carry();
        apply(3'd5, 2'd0, 6'd9, 64'h00, 64'h00, 7'h61, 7'h01);
        chk("R9 rcl reduced count zero", fout, 7'h61);
        apply(3'd5, 2'd1, 6'd2, 64'h4000, 64'h0000, 7'h61, 7'h00);
        chk("R9 rcl carry from source", fout, 7'h61);
        apply(3'd6, 2'd1, 6'd17, 64'h8000, 64'h0, 7'h61, 7'h00);
        chk("R10 rcr reduced count zero", fout, 7'h20);
        apply(3'd6, 2'd0, 6'd3, 64'h04, 64'h0, 7'h61, 7'h00);
        chk("R10 rcr carry from source", fout, 7'h41);
    endtask

    task automatic t_select();
        apply(3'd0, 2'd0, 6'd1, 64'h80, 64'h00, 7'h01, 7'h7E);
        chk("R1 only CF selected", fout, 7'h7F);
        apply(3'd0, 2'd0, 6'd1, 64'h80, 64'h00, 7'h40, 7'h00);
        chk("R11 ECF alone follows carry rule", fout, 7'h40);
        apply(3'd0, 2'd0, 6'd1, 64'h80, 64'h00, 7'h00, 7'h33);
        chk("R1 nothing selected", fout, 7'h33);
    endtask

    task automatic t_status();
        apply(3'd1, 2'd3, 6'd1, 64'h0, 64'h8000_0000_0000_0000, 7'h1E, 7'h04);
        chk("R12 status on 64-bit result", fout, 7'h12);
        apply(3'd1, 2'd0, 6'd1, 64'h0, 64'hFF00, 7'h1E, 7'h00);
        chk("R12 zero in 8-bit lane", fout, 7'h0A);
    endtask

    task automatic t_sweep();
        logic [63:0] pats [4];
        logic [5:0]  amts [8];
        pats[0] = 64'h8000_0000_0000_0001; pats[1] = 64'hA5C3_0F1E_96B4_7D28;
        pats[2] = 64'h0000_0000_0000_8080; pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        amts[0] = 6'd1;  amts[1] = 6'd7;  amts[2] = 6'd8;  amts[3] = 6'd9;
        amts[4] = 6'd16; amts[5] = 6'd17; amts[6] = 6'd31; amts[7] = 6'd63;
        for (int k = 0; k < 7; k++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ai = 0; ai < 8; ai++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [63:0] rv;
                        logic [6:0]  f;
                        rv = {pats[p][31:0], pats[(p+1)%4][63:32]} ^ {8{amts[ai], 2'b01}};
                        f  = 7'(p * 37 + ai);
                        apply(3'(k), 2'(s), amts[ai], pats[p], rv, 7'h7F, f);
                        chk(kind_req(k), fout, model(3'(k), 2'(s), amts[ai], pats[p], rv, 7'h7F, f));
                    end
                end
            end
        end
    endtask

    initial begin
        src = '0; res = '0; amt = '0; kind = '0; size = '0; sel = '0; fin = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_count_mask();
        t_shl();
        t_shr_clamp();
        t_sar_clamp();
        t_rotates();
        t_rotate_carry();
        t_select();
        t_status();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule